// File: doc/BRIEF.md
# Cached DRAM Bus Controller

This block sits between a 32-bit processor local bus and a single bank of DRAM that has an on-chip page cache. On every rising clock edge it looks at the bus strobe and the read/write line and sorts each access into one of three kinds. A read-miss opens a new row and loads it into the page cache. A read-hit reads a column from the row that is already cached. A write always goes through a row activation. The block drives the DRAM row enable, column strobe, write enable, the combined write/output-enable line, the refresh line, and the row/column select lines that steer the shared address pins. It holds the processor back by raising the ready line for as many wait states as the access needs.

Refresh requests come from a periodic processor timer pulse. The block latches each request and serves it in the first free bus slot, never in the middle of an access. While the processor's reset input is low, it runs refresh cycles back to back so the device sees its start-up refreshes. Chip-select decoding and the data path are outside this block.

Top module: `cdram_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, all outputs are inactive: `rdy_n`=1 (not ready), `row_sel`, `col_sel`, `row_en`, `col_stb`, `wr_en` and `ref_en` are 0, and `oe_wr`=1.
- R2: While `cpu_reset_n` is low, the controller performs refresh pairs continuously. `ref_en` is high in every cycle after the first edge, and at least 8 refresh starts occur within 16 cycles.
- R3: A read whose row differs from the cached row, or arrives when no row is cached, is a miss. It gives one cycle with `row_sel`, `row_en` and `oe_wr`=0, then one ready cycle (`rdy_n`=0) with `col_sel`, `col_stb` and `oe_wr`=0. Counting the decode cycle, that is 2 wait states.
- R4: A read to the cached row (row = `addr[18:8]`) is a hit. It goes straight to the ready column cycle with no `row_en`, which is 1 wait state. Only read-misses replace the cached row. Writes and refreshes leave it alone, and `cpu_reset_n` low invalidates it.
- R5: A write always takes a row cycle (`row_en`, `wr_en`) and then a ready column cycle (`col_stb`, `wr_en`), with `oe_wr`=1. That is 2 wait states whether the row is cached or not.
- R6: `ma[10:8]` always equals `addr[18:16]`. `ma[7:0]` equals `addr[7:0]` while `col_sel` is high and `addr[15:8]` otherwise.
- R7: A rising edge of `tick` sets a pending refresh request, which is cleared when a refresh starts. Further edges while it is pending merge into one refresh. An edge in the cycle a refresh starts stays pending.
- R8: A pending refresh starts from idle when `strb_n` is high, or straight after a ready cycle. When a strobe and a pending request meet at idle decode, the access goes first. The second refresh cycle dispatches a waiting strobe directly.
- R9: Outside processor reset, no access sees more than 3 wait states. A wait state is a cycle with `strb_n` low and `rdy_n` high.
- R10: `row_sel` and `col_sel` are never high together, and `col_stb` is high only while `col_sel` is high.
- R11: A refresh is two cycles with `ref_en` high and `rdy_n` high. The first cycle also has `row_en`, the second does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor output clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cpu_reset_n | input | 1 | Processor reset; low forces continuous refresh |
| strb_n | input | 1 | Bus access strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| tick | input | 1 | Periodic refresh timer pulse |
| addr | input | 19 | Local bus word address: row in [18:8], column in [7:0] |
| rdy_n | output | 1 | 0 = access completes this cycle, 1 = wait |
| row_sel | output | 1 | Steer row bits onto the address pins |
| col_sel | output | 1 | Steer column bits onto the address pins |
| row_en | output | 1 | DRAM row enable |
| col_stb | output | 1 | DRAM column strobe |
| wr_en | output | 1 | DRAM write enable |
| oe_wr | output | 1 | Combined write/output-enable, 0 = read |
| ref_en | output | 1 | DRAM refresh control |
| ma | output | 11 | Multiplexed DRAM address |

## Verification
Two functions can fall due in the same cycle: a refresh request that is already pending, and a new bus strobe being decoded at idle. The bench sets this up by pulsing `tick` during the ready cycle of one read, so the request is pending when the next read is decoded. It then pulses `tick` again during that read's row cycle. The result passes if the second read completes in 2 wait states, meaning the access won, and if exactly one refresh follows it, meaning the two edges merged. A separate sequence places the request so that a refresh occupies the slot just before a write, and checks that the write sees the 3-wait ceiling and no more.

// File: rtl/cdram_ctrl_pkg.sv
package cdram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ACT = 3'd1,
    ST_RD_COL = 3'd2,
    ST_WR_ACT = 3'd3,
    ST_WR_COL = 3'd4,
    ST_RF_A   = 3'd5,
    ST_RF_B   = 3'd6
  } ctrl_state_e;

  typedef struct packed {
    logic rdy_n;
    logic row_sel;
    logic col_sel;
    logic row_en;
    logic col_stb;
    logic wr_en;
    logic oe_wr;
    logic ref_en;
  } dram_ctl_t;

endpackage

// File: rtl/cdram_ref_req.sv
module cdram_ref_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic pend_o
);

  logic tick_q;
  logic pend_q;
  logic edge_w;
  logic pend_d;

  assign edge_w = tick_i & ~tick_q;

  always_comb begin
    pend_d = pend_q;
    if (start_i) pend_d = 1'b0;
    if (edge_w)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= tick_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7: a timer edge always leaves a request pending
  assert_tick_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !tick_q) |=> pend_o);

  // R7: starting a refresh without a fresh edge clears the request
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !(tick_i && !tick_q)) |=> !pend_o);

endmodule

// File: rtl/cdram_page_track.sv
module cdram_page_track #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o
);

  logic [ROW_W-1:0] open_row_q;
  logic             open_vld_q;
  logic             row_ce;

  assign row_ce = load_i & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld_q <= 1'b0;
    end else if (clr_i) begin
      open_vld_q <= 1'b0;
    end else if (load_i) begin
      open_vld_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row_q <= '0;
    end else if (row_ce) begin
      open_row_q <= row_i;
    end
  end

  assign hit_o = open_vld_q && (open_row_q == row_i);

  // R4: a row just loaded is reported as a hit while the address holds
  assert_load_gives_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) ##1 $stable(row_i) && !clr_i |-> hit_o);

  // R4: invalidation removes any hit
  assert_clear_kills_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !hit_o);

endmodule

// File: rtl/cdram_addr_mux.sv
module cdram_addr_mux #(
  parameter int COL_W  = 8,
  parameter int PASS_W = 3,
  localparam int ROW_W  = COL_W + PASS_W,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              col_sel_i,
  output logic [ROW_W-1:0]  ma_o
);

  for (genvar b = 0; b < ROW_W; b++) begin : g_pin
    if (b >= COL_W) begin : g_pass
      assign ma_o[b] = addr_i[b + COL_W];
    end else begin : g_mux
      assign ma_o[b] = col_sel_i ? addr_i[b] : addr_i[b + COL_W];
    end
  end

endmodule

// File: rtl/cdram_seq_fsm.sv
module cdram_seq_fsm
  import cdram_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpu_reset_n,
  input  logic      strb_n,
  input  logic      rd_wr,
  input  logic      hit_i,
  input  logic      pend_i,
  output logic      start_ref_o,
  output logic      load_row_o,
  output logic      clr_row_o,
  output dram_ctl_t ctl_o
);

  ctrl_state_e state_q;
  ctrl_state_e state_d;
  ctrl_state_e dispatch;

  always_comb begin
    if (!rd_wr)     dispatch = ST_WR_ACT;
    else if (hit_i) dispatch = ST_RD_COL;
    else            dispatch = ST_RD_ACT;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RF_B: begin
        if (!cpu_reset_n) state_d = ST_RF_A;
        else if (!strb_n) state_d = dispatch;
        else if (pend_i)  state_d = ST_RF_A;
        else              state_d = ST_IDLE;
      end
      ST_RD_ACT: state_d = cpu_reset_n ? ST_RD_COL : ST_RF_A;
      ST_WR_ACT: state_d = cpu_reset_n ? ST_WR_COL : ST_RF_A;
      ST_RD_COL, ST_WR_COL: begin
        if (!cpu_reset_n || pend_i) state_d = ST_RF_A;
        else                        state_d = ST_IDLE;
      end
      ST_RF_A: state_d = ST_RF_B;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign start_ref_o = (state_d == ST_RF_A);
  assign load_row_o  = (state_d == ST_RD_ACT);
  assign clr_row_o   = ~cpu_reset_n;

  always_comb begin
    ctl_o = '{rdy_n: 1'b1, row_sel: 1'b0, col_sel: 1'b0, row_en: 1'b0,
              col_stb: 1'b0, wr_en: 1'b0, oe_wr: 1'b1, ref_en: 1'b0};
    unique case (state_q)
      ST_RD_ACT: begin
        ctl_o.row_sel = 1'b1;
        ctl_o.row_en  = 1'b1;
        ctl_o.oe_wr   = 1'b0;
      end
      ST_RD_COL: begin
        ctl_o.col_sel = 1'b1;
        ctl_o.col_stb = 1'b1;
        ctl_o.oe_wr   = 1'b0;
        ctl_o.rdy_n   = 1'b0;
      end
      ST_WR_ACT: begin
        ctl_o.row_sel = 1'b1;
        ctl_o.row_en  = 1'b1;
        ctl_o.wr_en   = 1'b1;
      end
      ST_WR_COL: begin
        ctl_o.col_sel = 1'b1;
        ctl_o.col_stb = 1'b1;
        ctl_o.wr_en   = 1'b1;
        ctl_o.rdy_n   = 1'b0;
      end
      ST_RF_A: begin
        ctl_o.ref_en = 1'b1;
        ctl_o.row_en = 1'b1;
      end
      ST_RF_B: ctl_o.ref_en = 1'b1;
      default: ;
    endcase
  end

  // R2: processor reset keeps refresh running
  assert_reset_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_reset_n |=> ctl_o.ref_en);

  // R3: a read row cycle is followed by the ready column cycle
  assert_miss_then_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACT && cpu_reset_n) |=> (ctl_o.col_stb && !ctl_o.rdy_n && !ctl_o.oe_wr));

  // R4: a decoded hit skips row activation
  assert_hit_no_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE || state_q == ST_RF_B) && cpu_reset_n && !strb_n && rd_wr && hit_i)
      |=> (ctl_o.col_stb && !ctl_o.row_en));

  // R8: a strobe at idle decode beats a pending refresh
  assert_strobe_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cpu_reset_n && !strb_n && pend_i) |=> !ctl_o.ref_en);

  // R10: select lines exclusive, column strobe only under column select
  assert_sel_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_o.row_sel && ctl_o.col_sel) && (!ctl_o.col_stb || ctl_o.col_sel));

  // R11: first refresh cycle leads to the second without row enable
  assert_refresh_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o.ref_en && ctl_o.row_en) |=> (ctl_o.ref_en && !ctl_o.row_en && ctl_o.rdy_n));

endmodule

// File: rtl/cdram_bus_ctrl.sv
module cdram_bus_ctrl
  import cdram_ctrl_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int PASS_W   = 3,
  parameter int WAIT_MAX = 3,
  localparam int ROW_W   = COL_W + PASS_W,
  localparam int ADDR_W  = COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_reset_n,
  input  logic              strb_n,
  input  logic              rd_wr,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  output logic              rdy_n,
  output logic              row_sel,
  output logic              col_sel,
  output logic              row_en,
  output logic              col_stb,
  output logic              wr_en,
  output logic              oe_wr,
  output logic              ref_en,
  output logic [ROW_W-1:0]  ma
);

  localparam int CNT_W = $clog2(WAIT_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WAIT_MAX + 1);

  logic      pend;
  logic      start_ref;
  logic      load_row;
  logic      clr_row;
  logic      hit;
  dram_ctl_t ctl;

  cdram_ref_req u_ref_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .start_i (start_ref),
    .pend_o  (pend)
  );

  cdram_page_track #(.ROW_W(ROW_W)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_row),
    .load_i (load_row),
    .row_i  (addr[ADDR_W-1:COL_W]),
    .hit_o  (hit)
  );

  cdram_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_reset_n (cpu_reset_n),
    .strb_n      (strb_n),
    .rd_wr       (rd_wr),
    .hit_i       (hit),
    .pend_i      (pend),
    .start_ref_o (start_ref),
    .load_row_o  (load_row),
    .clr_row_o   (clr_row),
    .ctl_o       (ctl)
  );

  cdram_addr_mux #(.COL_W(COL_W), .PASS_W(PASS_W)) u_mux (
    .addr_i    (addr),
    .col_sel_i (ctl.col_sel),
    .ma_o      (ma)
  );

  assign rdy_n   = ctl.rdy_n;
  assign row_sel = ctl.row_sel;
  assign col_sel = ctl.col_sel;
  assign row_en  = ctl.row_en;
  assign col_stb = ctl.col_stb;
  assign wr_en   = ctl.wr_en;
  assign oe_wr   = ctl.oe_wr;
  assign ref_en  = ctl.ref_en;

  // Wait-state watch for R9
  logic [CNT_W-1:0] wait_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt_q <= '0;
    end else if (!cpu_reset_n || strb_n || !rdy_n) begin
      wait_cnt_q <= '0;
    end else if (wait_cnt_q != CNT_SAT) begin
      wait_cnt_q <= wait_cnt_q + 1'b1;
    end
  end

  assert_wait_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt_q <= CNT_W'(WAIT_MAX));

  // R6: upper address pins follow the upper bus bits
  assert_pass_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ma[ROW_W-1:COL_W] == addr[ADDR_W-1:ADDR_W-PASS_W]);

endmodule

// File: tb/cdram_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module cdram_bus_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_reset_n;
  logic        strb_n;
  logic        rd_wr;
  logic        tick;
  logic [18:0] addr;
  logic        rdy_n, row_sel, col_sel, row_en, col_stb, wr_en, oe_wr, ref_en;
  logic [10:0] ma;

  always #5 clk = ~clk;

  cdram_bus_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .cpu_reset_n (cpu_reset_n), .strb_n (strb_n),
    .rd_wr (rd_wr), .tick (tick), .addr (addr), .rdy_n (rdy_n),
    .row_sel (row_sel), .col_sel (col_sel), .row_en (row_en), .col_stb (col_stb),
    .wr_en (wr_en), .oe_wr (oe_wr), .ref_en (ref_en), .ma (ma)
  );

  typedef struct {
    bit          rd;
    logic [10:0] row;
    logic [10:0] col;
    int          waits;
    bit          miss;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   done_cnt = 0;
  int   f1_cnt = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: samples 3 ns after each falling edge
  int  m_waits = 0;
  bit  m_row   = 0;
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (ref_en && row_en) f1_cnt++;
      if ((row_sel && col_sel) || (col_stb && !col_sel))
        chk(1'b0, "R10 select overlap", {row_sel, col_sel, col_stb}, 0);
      if (q.size() > 0 && !strb_n) begin
        if (rdy_n) begin
          m_waits++;
          if (row_en && !ref_en) begin
            m_row = 1;
            chk(ma == q[0].row, "R6 row address", ma, q[0].row);
          end
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(m_waits == e.waits, {e.tag, " wait count"}, m_waits, e.waits);
          chk(m_row == e.miss, {e.tag, " row activation"}, m_row, e.miss);
          chk(col_stb && ma == e.col, "R6 column address", ma, e.col);
          chk(oe_wr == !e.rd, {e.tag, " oe_wr"}, oe_wr, !e.rd);
          chk(wr_en == !e.rd, {e.tag, " wr_en"}, wr_en, !e.rd);
          m_waits = 0;
          m_row   = 0;
          done_cnt++;
        end
      end
    end
  end

  // Driver: entered and left on a falling edge
  task automatic xfer(input bit rd, input logic [18:0] a, input int ew,
                      input bit emiss, input string tag, input logic [7:0] tmask);
    exp_t e;
    int   target;
    int   i;
    e.rd = rd; e.row = a[18:8]; e.col = {a[18:16], a[7:0]};
    e.waits = ew; e.miss = emiss; e.tag = tag;
    q.push_back(e);
    target = done_cnt + 1;
    strb_n = 1'b0; rd_wr = rd; addr = a; tick = tmask[0];
    i = 1;
    forever begin
      @(negedge clk);
      if (done_cnt >= target) break;
      if (i < 8) tick = tmask[i];
      i++;
    end
  endtask

  task automatic idle(input int n, input logic [15:0] tmask);
    strb_n = 1'b1;
    for (int k = 0; k < n; k++) begin
      tick = (k < 16) ? tmask[k] : 1'b0;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int c0;
    int rc;
    rst_n = 1'b0; cpu_reset_n = 1'b0; strb_n = 1'b1; rd_wr = 1'b1;
    tick = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    #3;
    // R1: reset state
    chk(rdy_n && !row_sel && !col_sel && !row_en && !col_stb && !wr_en && oe_wr && !ref_en,
        "R1 idle outputs", {rdy_n, row_sel, col_sel, row_en, col_stb, wr_en, oe_wr, ref_en}, 8'b1000_0010);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: refresh runs continuously while processor reset is low
    rc = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      #3;
      if (ref_en && row_en) rc++;
      if (!ref_en) chk(1'b0, "R2 refresh gap", k, -1);
    end
    chk(rc >= 8, "R2 refresh count", rc, 8);
    @(negedge clk);
    cpu_reset_n = 1'b1;
    idle(5, 16'h0);
    #3;
    chk(!ref_en && rdy_n, "R2 refresh stops after reset", ref_en, 0);
    @(negedge clk);

    // R3 miss, R4 hits
    xfer(1, {11'h012, 8'h10}, 2, 1, "R3", 8'h00);
    xfer(1, {11'h012, 8'h11}, 1, 0, "R4", 8'h00);
    c0 = f1_cnt;
    // R8: tick at hit decode, refresh takes the slot after ready; write sees 3 waits (R9)
    xfer(1, {11'h012, 8'h12}, 1, 0, "R4", 8'h01);
    xfer(0, {11'h345, 8'h20}, 3, 1, "R9", 8'h00);
    chk(f1_cnt - c0 == 1, "R8 refresh between accesses", f1_cnt - c0, 1);
    // R4: write left cached row intact; R5 write with no refresh
    xfer(1, {11'h012, 8'h13}, 1, 0, "R4", 8'h00);
    xfer(0, {11'h012, 8'h14}, 2, 1, "R5", 8'h00);
    // Collision: request pending at decode, second tick merges (R7, R8)
    xfer(1, {11'h345, 8'h21}, 2, 1, "R3", 8'h04);
    c0 = f1_cnt;
    xfer(1, {11'h777, 8'h30}, 2, 1, "R8", 8'h02);
    idle(10, 16'h0);
    chk(f1_cnt - c0 == 1, "R7 merged refresh count", f1_cnt - c0, 1);
    // R11/R7: refresh from idle on a lone tick
    c0 = f1_cnt;
    idle(8, 16'h0001);
    chk(f1_cnt - c0 == 1, "R11 idle refresh count", f1_cnt - c0, 1);
    // R4: refresh keeps the cached row
    xfer(1, {11'h777, 8'h31}, 1, 0, "R4", 8'h00);
    // R4: processor reset invalidates cached row
    cpu_reset_n = 1'b0;
    idle(3, 16'h0);
    cpu_reset_n = 1'b1;
    idle(4, 16'h0);
    xfer(1, {11'h777, 8'h32}, 2, 1, "R4", 8'h00);
    idle(2, 16'h0);
    chk(q.size() == 0, "R3 all accesses completed", q.size(), 0);
    finish_run();
  end

endmodule